// File: doc/BRIEF.md
# BCD clock-calendar core

This block holds the time of day and the calendar date as eight packed BCD bytes: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A one-cycle `tick_100hz` enable, produced by a divider outside the block, advances the time by one hundredth. Hours run either as a 24-hour count or as a 12-hour count with a PM flag. The date rolls over at the real length of each month, and February gains its 29th day in every year whose two-digit value is a multiple of four. That rule holds up to the year 2100.

The whole state is visible at all times on a 64-bit read port for a serial access front end. A 64-bit parallel load port overwrites it in one cycle. The load is masked, so unused bits always read 0. The day byte also carries two control bits. One freezes the time. The other is passed out on `rst_enable_out` so that the access controller can decide whether it honours its external reset pin.

Each tick is carried through the fields by a small state machine, one field per clock cycle. The states are `ST_IDLE`, `ST_HUND`, `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DATE`, `ST_MONTH` and `ST_YEAR`. The transitions are:
- *start*: `ST_IDLE` to `ST_HUND` on a tick, or on a remembered tick, while the time is not frozen.
- *carry*: from each field state to the next field state when the field wraps.
- *settle*: from a field state back to `ST_IDLE` when the field does not wrap. `ST_YEAR` always settles.
- *abort*: from any state to `ST_IDLE` when a load occurs.

At most seven clock cycles after the tick, the time is settled.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the read port shows 64'h0001_0101_0000_0000, and `rst_enable_out` is 0. Reading from the most significant byte down, the bytes are year, month, date, day, hours, minutes, seconds and hundredths. This gives year 00, month 01, date 01, day 1 and 00:00:00.00 in 24-hour mode with the time running.
- R2: Each tick adds one to the hundredths in BCD. Hundredths wrap from 99 to 00, and seconds and minutes wrap from 59 to 00. Each wrap carries one into the next field up.
- R3: In 24-hour mode (hours bit 7 = 0), hours bits 5:0 count 00 to 23 in BCD, with bit 5 as the tens bit for 20 to 23. A step past 23 gives 00 and carries into the date.
- R4: In 12-hour mode (hours bit 7 = 1), hours bits 4:0 run 12, 01 through 11 in BCD and bit 5 is the PM flag (1 = PM). The step from 11 to 12 toggles PM. The step from 11 PM to 12 AM also carries into the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The wrap carries into the month.
- R6: February ends on 29 when the year is a multiple of 4, and on 28 otherwise.
- R7: The day of week (day bits 2:0) steps with every date increment and wraps from 7 to 1.
- R8: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R9: While day bit 5 is 1, ticks are ignored and the time does not change.
- R10: `rst_enable_out` follows day bit 4.
- R11: Bits not used by a field always read 0. The load mask is 64'hFF1F_3F37_BF7F_7FFF.
- R12: A load takes effect in the next cycle. It has priority over a tick in the same cycle, and it ends any carry still in progress.
- R13: A tick that arrives while a carry is in progress is held and applied after the carry finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle enable, once per hundredth of a second |
| load_en | input | 1 | Load the whole time from `load_data` |
| load_data | input | 64 | New time, in the same byte layout as `time_out` |
| time_out | output | 64 | Current time, eight BCD bytes |
| rst_enable_out | output | 1 | Reset-enable control bit from the day byte |

## Verification
The bench goes after the rollover edges where a wrong carry chain gives plausible but wrong dates. These are 23:59:59.99 into a new day, 11 PM into 12 AM, and 30-day and 31-day month ends. It also tests February in leap and non-leap years, including a year with an odd tens digit, and 99 December 31 into year 00. A design that miscounted these would skip a date, repeat a date, or leave the AM/PM flag wrong. Directed tests cover the cases that depend on timing. A load in the same cycle as a tick must win, so a design that got it wrong would show an extra hundredth. A load in the middle of a carry must leave the loaded value intact, where a wrong design would corrupt a field. A second tick during a carry must not be lost, and the freeze bit must hold the time still.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUND,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } rtc_state_e;

    // Byte index of each field on the 64-bit time bus
    localparam logic [2:0] IDX_HUND  = 3'd0;
    localparam logic [2:0] IDX_SEC   = 3'd1;
    localparam logic [2:0] IDX_MIN   = 3'd2;
    localparam logic [2:0] IDX_HOUR  = 3'd3;
    localparam logic [2:0] IDX_DAY   = 3'd4;
    localparam logic [2:0] IDX_DATE  = 3'd5;
    localparam logic [2:0] IDX_MONTH = 3'd6;
    localparam logic [2:0] IDX_YEAR  = 3'd7;

    localparam int FREEZE_BIT = 37;  // day byte bit 5
    localparam int RSTEN_BIT  = 36;  // day byte bit 4

    localparam logic [63:0] LOAD_MASK  = 64'hFF1F_3F37_BF7F_7FFF;
    localparam logic [63:0] RESET_TIME = 64'h0001_0101_0000_0000;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic rtc_state_e next_field(input rtc_state_e s);
        unique case (s)
            ST_HUND:  return ST_SEC;
            ST_SEC:   return ST_MIN;
            ST_MIN:   return ST_HOUR;
            ST_HOUR:  return ST_DATE;
            ST_DATE:  return ST_MONTH;
            ST_MONTH: return ST_YEAR;
            default:  return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rtc_month_days.sv
module rtc_month_days (
    input  logic [7:0] month_bcd,
    input  logic [7:0] year_bcd,
    output logic [5:0] last_date
);
    logic [1:0] yr_mod4;
    logic       leap;

    // 10*tens mod 4 equals 2*tens[0] mod 4
    assign yr_mod4 = year_bcd[1:0] + {year_bcd[4], 1'b0};
    assign leap    = (yr_mod4 == 2'b00);

    always_comb begin
        unique case (month_bcd)
            8'h02:                      last_date = leap ? 6'h29 : 6'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_field_step.sv
module rtc_field_step
    import rtc_pkg::*;
(
    input  rtc_state_e  state,
    input  logic [63:0] now,
    input  logic [5:0]  last_date,
    output logic [2:0]  field_idx,
    output logic [7:0]  field_next,
    output logic        carry,
    output logic        dow_wr,
    output logic [7:0]  dow_next
);
    logic [7:0] hund, sec, mins, hour, day, date, mon, yr;
    logic [7:0] hr12, hr24, hr12_inc, hr24_inc;

    assign hund = now[7:0];
    assign sec  = now[15:8];
    assign mins = now[23:16];
    assign hour = now[31:24];
    assign day  = now[39:32];
    assign date = now[47:40];
    assign mon  = now[55:48];
    assign yr   = now[63:56];

    assign hr12     = {3'b000, hour[4:0]};
    assign hr24     = {2'b00, hour[5:0]};
    assign hr12_inc = bcd_inc(hr12);
    assign hr24_inc = bcd_inc(hr24);

    always_comb begin
        field_idx  = IDX_HUND;
        field_next = hund;
        carry      = 1'b0;
        dow_wr     = 1'b0;
        dow_next   = day;
        unique case (state)
            ST_IDLE: ;
            ST_HUND: begin
                field_idx  = IDX_HUND;
                carry      = (hund == 8'h99);
                field_next = carry ? 8'h00 : bcd_inc(hund);
            end
            ST_SEC: begin
                field_idx  = IDX_SEC;
                carry      = (sec == 8'h59);
                field_next = carry ? 8'h00 : bcd_inc(sec);
            end
            ST_MIN: begin
                field_idx  = IDX_MIN;
                carry      = (mins == 8'h59);
                field_next = carry ? 8'h00 : bcd_inc(mins);
            end
            ST_HOUR: begin
                field_idx = IDX_HOUR;
                if (hour[7]) begin
                    if (hr12 == 8'h12) begin
                        field_next = {2'b10, hour[5], 5'h01};
                    end else if (hr12 == 8'h11) begin
                        field_next = {2'b10, ~hour[5], 5'h12};
                        carry      = hour[5];
                    end else begin
                        field_next = {2'b10, hour[5], hr12_inc[4:0]};
                    end
                end else begin
                    carry      = (hr24 == 8'h23);
                    field_next = carry ? 8'h00 : {2'b00, hr24_inc[5:0]};
                end
            end
            ST_DATE: begin
                field_idx  = IDX_DATE;
                carry      = (date[5:0] == last_date);
                field_next = carry ? 8'h01 : bcd_inc(date);
                dow_wr     = 1'b1;
                dow_next   = {day[7:3], (day[2:0] == 3'd7) ? 3'd1 : day[2:0] + 3'd1};
            end
            ST_MONTH: begin
                field_idx  = IDX_MONTH;
                carry      = (mon == 8'h12);
                field_next = carry ? 8'h01 : bcd_inc(mon);
            end
            ST_YEAR: begin
                field_idx  = IDX_YEAR;
                carry      = (yr == 8'h99);
                field_next = carry ? 8'h00 : bcd_inc(yr);
            end
        endcase
    end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter  int FIELD_W    = 8,
    parameter  int NUM_FIELDS = 8,
    localparam int BUS_W      = FIELD_W * NUM_FIELDS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_100hz,
    input  logic             load_en,
    input  logic [BUS_W-1:0] load_data,
    output logic [BUS_W-1:0] time_out,
    output logic             rst_enable_out
);
    localparam int DOW_LSB = int'(IDX_DAY) * FIELD_W;

    rtc_state_e       state_q, state_d;
    logic             pending_q;
    logic [BUS_W-1:0] time_q;
    logic [5:0]       last_date;
    logic [2:0]       field_idx;
    logic [7:0]       field_next, dow_next;
    logic             carry, dow_wr;
    logic             field_we, dow_we, frozen;

    rtc_month_days days_i (
        .month_bcd (time_q[55:48]),
        .year_bcd  (time_q[63:56]),
        .last_date (last_date)
    );

    rtc_field_step step_i (
        .state      (state_q),
        .now        (time_q),
        .last_date  (last_date),
        .field_idx  (field_idx),
        .field_next (field_next),
        .carry      (carry),
        .dow_wr     (dow_wr),
        .dow_next   (dow_next)
    );

    assign frozen = time_q[FREEZE_BIT];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!load_en && (tick_100hz || pending_q) && !frozen)
                    state_d = ST_HUND;
            end
            default: begin
                if (load_en)    state_d = ST_IDLE;
                else if (carry) state_d = next_field(state_q);
                else            state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        field_we = (state_q != ST_IDLE) && !load_en;
        dow_we   = field_we && dow_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                     pending_q <= 1'b0;
        else if (load_en)               pending_q <= 1'b0;
        else if (state_q == ST_IDLE)    pending_q <= 1'b0;
        else if (tick_100hz)            pending_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= RESET_TIME;
        end else if (load_en) begin
            time_q <= load_data & LOAD_MASK;
        end else begin
            if (field_we) time_q[int'(field_idx) * FIELD_W +: FIELD_W] <= field_next;
            if (dow_we)   time_q[DOW_LSB +: FIELD_W] <= dow_next;
        end
    end

    assign time_out       = time_q;
    assign rst_enable_out = time_q[RSTEN_BIT];
endmodule

// File: rtl/bcd_rtc_core_checker.sv
module bcd_rtc_core_checker
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        load_en,
    input logic [63:0] load_data,
    input logic [63:0] time_out
);
    // R11: masked bits stay zero
    assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (time_out & ~LOAD_MASK) == 64'h0);

    // R12: load lands in the next cycle regardless of tick or carry
    assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (time_out == ($past(load_data) & LOAD_MASK)));

    // R9: frozen time does not move
    assert_freeze_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (time_out[FREEZE_BIT] && !load_en) |=> $stable(time_out));

    // R7: day of week only moves together with the date
    assert_dow_with_date_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(time_out[34:32]) || !$stable(time_out[45:40])));
endmodule

bind bcd_rtc_core bcd_rtc_core_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_data (load_data),
    .time_out  (time_out)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;
    // {requirement tag, start time, expected time after one tick}
    localparam logic [143:0] VECS [NVEC] = '{
        {"R2", 64'h0001_0101_0000_0000, 64'h0001_0101_0000_0001},
        {"R2", 64'h0001_0101_0000_0009, 64'h0001_0101_0000_0010},
        {"R2", 64'h0001_0101_0000_5999, 64'h0001_0101_0001_0000},
        {"R2", 64'h0001_0101_0059_5999, 64'h0001_0101_0100_0000},
        {"R3", 64'h2406_1503_2359_5999, 64'h2406_1604_0000_0000},
        {"R3", 64'h2406_1503_1959_5999, 64'h2406_1503_2000_0000},
        {"R4", 64'h2406_1503_9159_5999, 64'h2406_1503_B200_0000},
        {"R4", 64'h2406_1503_B259_5999, 64'h2406_1503_A100_0000},
        {"R7", 64'h2406_1507_B159_5999, 64'h2406_1601_9200_0000},
        {"R4", 64'h2406_1503_9259_5999, 64'h2406_1503_8100_0000},
        {"R5", 64'h2404_3002_2359_5999, 64'h2405_0103_0000_0000},
        {"R5", 64'h2301_3102_2359_5999, 64'h2302_0103_0000_0000},
        {"R6", 64'h2302_2802_2359_5999, 64'h2303_0103_0000_0000},
        {"R6", 64'h2402_2802_2359_5999, 64'h2402_2903_0000_0000},
        {"R6", 64'h2402_2902_2359_5999, 64'h2403_0103_0000_0000},
        {"R6", 64'h1202_2802_2359_5999, 64'h1202_2903_0000_0000},
        {"R8", 64'h9912_3105_2359_5999, 64'h0001_0106_0000_0000},
        {"R8", 64'h2412_3105_2359_5999, 64'h2501_0106_0000_0000},
        {"R5", 64'h2409_3001_2359_5999, 64'h2410_0102_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_100hz = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] time_out;
    logic        rst_enable_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_rtc_core dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_100hz     (tick_100hz),
        .load_en        (load_en),
        .load_data      (load_data),
        .time_out       (time_out),
        .rst_enable_out (rst_enable_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_time(input logic [63:0] v);
        @(negedge clk); load_en = 1'b1; load_data = v;
        @(negedge clk); load_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick_100hz = 1'b1;
        @(negedge clk); tick_100hz = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", time_out, 64'h0001_0101_0000_0000);
        check("R1", {63'd0, rst_enable_out}, 64'd0);

        // table of single-tick rollovers
        for (int i = 0; i < NVEC; i++) begin
            load_time(VECS[i][127:64]);
            pulse_tick();
            settle();
            check(string'(VECS[i][143:128]), time_out, VECS[i][63:0]);
        end

        // R11 and R10: all-ones load is masked; reset-enable bit visible
        load_time(64'hFFFF_FFFF_FFFF_FFFF);
        check("R11", time_out, 64'hFF1F_3F37_BF7F_7FFF);
        check("R10", {63'd0, rst_enable_out}, 64'd1);

        // R9: frozen time ignores ticks, resumes when cleared
        load_time(64'h2406_1523_0000_0005);
        for (int k = 0; k < 3; k++) begin
            pulse_tick();
            settle();
        end
        check("R9", time_out, 64'h2406_1523_0000_0005);
        load_time(64'h2406_1503_0000_0005);
        pulse_tick();
        settle();
        check("R9", time_out, 64'h2406_1503_0000_0006);

        // R10: follows day bit 4 both ways
        load_time(64'h2406_1513_0000_0000);
        check("R10", {63'd0, rst_enable_out}, 64'd1);
        load_time(64'h2406_1503_0000_0000);
        check("R10", {63'd0, rst_enable_out}, 64'd0);

        // R12: load and tick in the same cycle, load wins
        @(negedge clk); load_en = 1'b1; load_data = 64'h0001_0101_0000_0005; tick_100hz = 1'b1;
        @(negedge clk); load_en = 1'b0; tick_100hz = 1'b0;
        settle();
        check("R12", time_out, 64'h0001_0101_0000_0005);

        // R12: load in the middle of a carry ends it
        load_time(64'h0001_0101_0059_5999);
        @(negedge clk); tick_100hz = 1'b1;
        @(negedge clk); tick_100hz = 1'b0; load_en = 1'b1; load_data = 64'h2406_1503_1020_3040;
        @(negedge clk); load_en = 1'b0;
        settle();
        check("R12", time_out, 64'h2406_1503_1020_3040);

        // R13: second tick during carry is not lost
        load_time(64'h0001_0101_0000_0098);
        @(negedge clk); tick_100hz = 1'b1;
        @(negedge clk);
        @(negedge clk); tick_100hz = 1'b0;
        settle();
        check("R13", time_out, 64'h0001_0101_0000_0100);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule